// File: doc/BRIEF.md
# Six-Step Three-Phase Commutation Sequencer

The sequencer produces the six gate-enable levels for a three-phase bridge run in six-step mode. An external rate clock, usually from a voltage-controlled oscillator, is synchronised into the system clock domain. Each rising edge of that clock moves an electrical angle counter forward by one tick of 15 degrees, so one electrical revolution takes 24 ticks. Because of this, the output frequency follows the oscillator. The three legs use the same pattern, and each leg is displaced from the one before it by 8 ticks (120 degrees).

Each leg has an upper switch and a lower switch. Each switch owns half of the revolution. It gives up the first tick of its half as a dead interval, so the two switches of a leg never overlap, and the dead angle stays the same at every speed. Upper outputs drive isolation couplers, so while on they follow a high-frequency carrier input. Lower outputs are steady levels. A fault-inhibit input blanks every output at once. Dropping the enable input parks the sequence at angle zero. A reverse input exchanges the roles of the second and third legs, which reverses the rotation.

Top module: `sixstep_seq`

## Requirements
- R1: While rst_ni is low, all six outputs (hi_o, lo_o) are 0.
- R2: The angle advances by exactly one tick per rising edge of rate_i while en_i is high. A rate_i held high for many clock cycles gives one advance only. After 24 advances the pattern repeats.
- R3: Leg k has a local angle, equal to (angle − offset_k) mod 24. Its upper window covers local angles 1..11 and its lower window covers 13..23. Both switches are off at local angles 0 and 12, so each switch conducts for at most 11 ticks (165 degrees).
- R4: The upper and lower outputs of one leg are never 1 in the same cycle.
- R5: With reverse_i = 0, the leg offsets are 0 for bit 0 (phase A), 8 for bit 1 (phase B) and 16 for bit 2 (phase C). Phase B therefore lags A by 120 degrees, and C lags B by 120 degrees.
- R6: With reverse_i = 1, the offsets of bit 1 and bit 2 are exchanged (16 and 8).
- R7: An upper output equals its window ANDed with carrier_i in the same cycle. A lower output is a steady 1 throughout its window.
- R8: While inhibit_i is 1, all six outputs are 0 in that same cycle. The angle keeps advancing, and the outputs take up the current angle once inhibit_i is released.
- R9: When en_i is low, the outputs go to 0 and the angle returns to zero.
- R10: After en_i rises, every output stays 0 until the first rate edge. That edge moves the angle to 1, which opens the first windows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Run enable; low parks the sequence at angle zero |
| inhibit_i | input | 1 | Fault inhibit; forces all outputs off immediately |
| reverse_i | input | 1 | Exchanges phase B and C offsets |
| rate_i | input | 1 | Asynchronous angle clock, one tick per rising edge |
| carrier_i | input | 1 | Coupler carrier gated onto upper outputs |
| hi_o | output | 3 | Upper switch enables, bit k = phase k |
| lo_o | output | 3 | Lower switch enables, bit k = phase k |

## Verification
The assertions check, on every clock, the following properties. The two switches of a leg never overlap. An upper output is never high without the carrier. Inhibit blanks every output. The angle stays in range, steps by one per detected edge and clears when enable is low. The synchronised edge is a single-cycle pulse. Whether the right leg conducts at the right angle cannot be checked this way. This covers the 120-degree offsets, the swap under reverse, the wait for the first edge after enable, and the count continuing through an inhibit. Only the bench scenarios can show these, by comparing all six outputs after each tick against a model of the 24-tick pattern.

// File: rtl/sixstep_pkg.sv
package sixstep_pkg;
  localparam int unsigned NUM_LEGS = 3;
  localparam int unsigned DEF_TICKS = 24;
  localparam int unsigned DEF_DEAD = 1;
  localparam int unsigned DEF_SYNC = 2;
endpackage

// File: rtl/sixstep_rate_edge.sv
module sixstep_rate_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rate_i,
  output logic tick_o
);
  logic [SYNC_STAGES:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-1:0], rate_i};
  end

  assign tick_o = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];

  // one pulse per edge, however long rate_i stays high
  assert_single_tick_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/sixstep_angle.sv
module sixstep_angle #(
  parameter int unsigned TICKS = 24,
  localparam int unsigned ANG_W = $clog2(TICKS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  output logic [ANG_W-1:0] angle_o,
  output logic             started_o
);
  localparam logic [ANG_W-1:0] LAST = ANG_W'(TICKS - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      angle_o   <= '0;
      started_o <= 1'b0;
    end else if (!en_i) begin
      angle_o   <= '0;
      started_o <= 1'b0;
    end else if (tick_i) begin
      angle_o   <= (angle_o == LAST) ? '0 : angle_o + 1'b1;
      started_o <= 1'b1;
    end
  end

  assert_angle_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    angle_o <= LAST);
  assert_angle_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tick_i) |=> ((angle_o == 0 && $past(angle_o) == LAST) ||
                          (angle_o == $past(angle_o) + 1'b1)));
  assert_angle_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !tick_i) |=> $stable(angle_o));
  assert_park_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (angle_o == 0 && !started_o));
endmodule

// File: rtl/sixstep_leg.sv
module sixstep_leg #(
  parameter int unsigned TICKS = 24,
  parameter int unsigned DEAD  = 1,
  localparam int unsigned ANG_W = $clog2(TICKS),
  localparam int unsigned HALF  = TICKS / 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ANG_W-1:0] angle_i,
  input  logic [ANG_W-1:0] offset_i,
  input  logic             started_i,
  input  logic             carrier_i,
  input  logic             inhibit_i,
  output logic             hi_o,
  output logic             lo_o
);
  logic [ANG_W:0]   wide_sum;
  logic [ANG_W-1:0] local_ang;
  logic             hi_win, lo_win;

  always_comb begin
    wide_sum = {1'b0, angle_i} + (ANG_W+1)'(TICKS) - {1'b0, offset_i};
    if (wide_sum >= (ANG_W+1)'(TICKS)) wide_sum = wide_sum - (ANG_W+1)'(TICKS);
    local_ang = wide_sum[ANG_W-1:0];
  end

  assign hi_win = (local_ang >= ANG_W'(DEAD)) && (local_ang < ANG_W'(HALF));
  assign lo_win = (local_ang >= ANG_W'(HALF + DEAD));

  assign hi_o = hi_win & started_i & carrier_i & ~inhibit_i;
  assign lo_o = lo_win & started_i & ~inhibit_i;

  assert_no_shoot_through_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hi_o && lo_o));
  assert_hi_needs_carrier_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_o |-> carrier_i);
  assert_inhibit_blanks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inhibit_i |-> (!hi_o && !lo_o));
endmodule

// File: rtl/sixstep_seq.sv
module sixstep_seq
  import sixstep_pkg::*;
#(
  parameter int unsigned TICKS       = DEF_TICKS,
  parameter int unsigned DEAD        = DEF_DEAD,
  parameter int unsigned SYNC_STAGES = DEF_SYNC
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic                inhibit_i,
  input  logic                reverse_i,
  input  logic                rate_i,
  input  logic                carrier_i,
  output logic [NUM_LEGS-1:0] hi_o,
  output logic [NUM_LEGS-1:0] lo_o
);
  localparam int unsigned ANG_W  = $clog2(TICKS);
  localparam int unsigned PH_OFF = TICKS / NUM_LEGS;

  logic             tick;
  logic [ANG_W-1:0] angle;
  logic             started;

  sixstep_rate_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rate_i (rate_i),
    .tick_o (tick)
  );

  sixstep_angle #(.TICKS(TICKS)) u_angle (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .tick_i    (tick),
    .angle_o   (angle),
    .started_o (started)
  );

  for (genvar k = 0; k < NUM_LEGS; k++) begin : g_leg
    logic [ANG_W-1:0] offset;
    // reverse mirrors leg order: leg k takes offset of leg NUM_LEGS-k
    if (k == 0) begin : g_ref
      assign offset = '0;
    end else begin : g_lag
      assign offset = reverse_i ? ANG_W'((NUM_LEGS - k) * PH_OFF) : ANG_W'(k * PH_OFF);
    end

    sixstep_leg #(.TICKS(TICKS), .DEAD(DEAD)) u_leg (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .angle_i   (angle),
      .offset_i  (offset),
      .started_i (started),
      .carrier_i (carrier_i),
      .inhibit_i (inhibit_i),
      .hi_o      (hi_o[k]),
      .lo_o      (lo_o[k])
    );
  end

  assert_quiet_before_start_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !started |-> (hi_o == '0 && lo_o == '0));
endmodule

// File: tb/sixstep_seq_test.sv
`timescale 1ns/1ps
module sixstep_seq_test;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic en = 1'b0, inh = 1'b0, rev = 1'b0, rate = 1'b0, car = 1'b0;
  logic [2:0] hi, lo;
  int n_run = 0, n_fail = 0;
  int ticks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sixstep_seq uut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .inhibit_i(inh),
    .reverse_i(rev), .rate_i(rate), .carrier_i(car), .hi_o(hi), .lo_o(lo)
  );

  function automatic logic [5:0] model(int t, bit rv, bit c, bit ih, bit e);
    logic [2:0] h = '0, l = '0;
    if (e && t > 0 && !ih) begin
      for (int k = 0; k < 3; k++) begin
        int off, a;
        off = (k == 0) ? 0 : (((k == 1) != rv) ? 8 : 16);
        a = ((t % 24) - off + 24) % 24;
        if (a >= 1 && a <= 11) h[k] = c;
        if (a >= 13) l[k] = 1'b1;
      end
    end
    return {h, l};
  endfunction

  task automatic check(string tag);
    logic [5:0] exp;
    #1;
    exp = model(ticks, rev, car, inh, en);
    n_run++;
    if ({hi, lo} !== exp) begin
      n_fail++;
      $display("FAIL %s t=%0d got hi=%b lo=%b exp hi=%b lo=%b", tag, ticks, hi, lo, exp[5:3], exp[2:0]);
    end
  endtask

  task automatic pulse(int high_cycles);
    @(negedge clk) rate = 1'b1;
    repeat (high_cycles) @(negedge clk);
    rate = 1'b0;
    repeat (4) @(negedge clk);
    if (en) ticks++;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    process::self().srandom(32'd1234);
    repeat (3) @(negedge clk);
    check("R1 reset");
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    en = 1'b1; car = 1'b1;
    repeat (6) @(negedge clk);
    check("R10 no output before first edge");
    // full forward revolution
    for (int s = 0; s < 24; s++) begin
      pulse(4);
      check("R3 R5 forward step");
      car = 1'b0; check("R7 carrier low");
      car = 1'b1;
    end
    // long high rate level gives a single advance
    pulse(30);
    check("R2 single advance on long high");
    // reverse revolution
    rev = 1'b1;
    for (int s = 0; s < 24; s++) begin
      pulse(4);
      check("R6 reverse step");
    end
    rev = 1'b0;
    // inhibit: count continues
    @(negedge clk) inh = 1'b1;
    check("R8 inhibit blanks");
    for (int s = 0; s < 5; s++) pulse(4);
    check("R8 inhibit held");
    @(negedge clk) inh = 1'b0;
    check("R8 resume at advanced angle");
    // enable drop parks angle
    @(negedge clk) en = 1'b0;
    repeat (3) @(negedge clk);
    ticks = 0;
    check("R9 disabled outputs off");
    pulse(4);
    check("R9 no advance while disabled");
    @(negedge clk) en = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 quiet after re-enable");
    pulse(4);
    check("R9 R10 restart at angle one");
    // random mix
    for (int i = 0; i < 200; i++) begin
      if ($urandom_range(0, 3) != 0) pulse($urandom_range(2, 8));
      @(negedge clk);
      rev = 1'($urandom_range(0, 1));
      car = 1'($urandom_range(0, 1));
      inh = ($urandom_range(0, 7) == 0);
      check("R2 R3 R4 R6 R7 R8 random");
    end
    inh = 1'b0;
    @(negedge clk) rst_ni = 1'b0;
    ticks = 0;
    check("R1 reset mid-run");
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule